// File: doc/BRIEF.md
# I2C Paged Serial EEPROM Controller

This block is an I2C target that presents a 256-byte memory to a bus master as if it were a serial EEPROM. The master selects it with a 7-bit address formed from a zero followed by six strap inputs. After the address it may load a word pointer and send data bytes, or read bytes starting at the current pointer. A random read is a pointer load followed by a repeated start and a read address. A sequential read continues for as long as the master acknowledges.

Written bytes are held in a 16-entry page buffer and are not placed in the array until a stop ends the write. The stop starts a write cycle whose length is a clock-cycle parameter. The buffered bytes are copied into a synchronous RAM during the first cycles of that window. For the whole window the block does not acknowledge its address, so a master can poll until the write has finished. A lock input held high at the stop throws the buffered bytes away and skips the write cycle.

SCL and SDA are sampled in the system clock domain, so the clock must run well above the bus rate. SDA is driven as open drain: `sda_oe` high pulls the line low.

Top module: `eep_i2c_slave`

## Requirements
- R1: The block acknowledges only the address byte whose upper seven bits are {0, dev_sel[5:0]}; bit 0 of that byte is 1 for a read and 0 for a write. Any other address is not acknowledged, and SDA stays released until the next start.
- R2: In a write, the first byte after the address loads the 8-bit word pointer. Every later byte is data, and each byte (pointer and data) is acknowledged.
- R3: Each data byte goes to the page slot given by the pointer's low 4 bits, and only those 4 bits then increment. After 16 bytes the pointer wraps within the 16-byte page and later bytes replace earlier ones; the last byte written to a slot wins.
- R4: A stop that ends a write carrying at least one data byte starts a write cycle of WR_CYCLES clock cycles. During that cycle the memory address is not acknowledged, and once it ends the address is acknowledged again.
- R5: If wr_lock is 1 at the stop, data bytes are still acknowledged and the pointer still advances, but the memory is left unchanged and no write cycle starts.
- R6: The pointer holds the last accessed address plus one. A read with no pointer load returns the byte at the pointer.
- R7: A pointer load followed by a repeated start and a read address returns the byte at the loaded pointer. A write with no data bytes starts no write cycle.
- R8: A master acknowledge after a read byte sends the byte at the next address, and the pointer wraps from 255 to 0. After a master not-acknowledge the block releases SDA and waits for a start or a stop.
- R9: A repeated start after data bytes discards the buffered bytes: nothing is written and no write cycle starts.
- R10: After reset SDA is released, the pointer is 0 and no write cycle is active. A reset leaves the memory contents unchanged.
- R11: The block changes SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| dev_sel | input | 6 | Strap bits forming the low six bits of the memory address |
| wr_lock | input | 1 | 1 blocks committing writes at the stop |

## Verification
The assertions check several properties on every clock. SDA stays quiet during a write cycle and only changes while SCL is low. Commit writes fall inside the write cycle, and a locked stop never starts one. All bytes of a page write stay in one page, and the pointer steps by one on each read byte. A wrong address leaves SDA released. The bench scenarios are needed for the rest: the data actually read back after page writes that overflow and wrap, after random and sequential reads across address 255, after a locked write and after a write dropped by a repeated start. They also show the polling behaviour, where the address is refused right after the stop and accepted once the write cycle is over.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WADDR,
    ST_WACK, ST_WDATA, ST_RDATA, ST_RACK
  } eep_state_t;
endpackage

// File: rtl/eep_bus_sense.sv
module eep_bus_sense (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [2:0] scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  assign scl_s    = scl_q[1];
  assign sda_s    = sda_q[1];
  assign scl_rise = scl_q[1] & ~scl_q[2];
  assign scl_fall = ~scl_q[1] & scl_q[2];
  assign start_ev = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  assign stop_ev  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
endmodule

// File: rtl/eep_mem.sv
module eep_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;
  logic [DW-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    rdata <= ram[raddr];
  end
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [PW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          any_valid,
  output logic [AW-PW-1:0] page
);
  localparam int SLOTS = 2 ** PW;
  logic [DW-1:0]    slot_q [SLOTS];
  logic [SLOTS-1:0] vld_q;
  logic [AW-PW-1:0] page_q;

  always_ff @(posedge clk) begin
    if (rst || clr) vld_q <= '0;
    else if (wr_en) vld_q[wr_addr[PW-1:0]] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      slot_q[wr_addr[PW-1:0]] <= wr_data;
      page_q <= wr_addr[AW-1:PW];
    end
  end

  assign rd_data   = slot_q[rd_idx];
  assign rd_valid  = vld_q[rd_idx];
  assign any_valid = |vld_q;
  assign page      = page_q;

  // R3: every byte buffered in one transaction lies in the same page
  p_page_stays_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && any_valid && !clr) |-> (wr_addr[AW-1:PW] == page_q));
endmodule

// File: rtl/eep_wr_cycle.sv
module eep_wr_cycle #(
  parameter int WR_CYCLES = 250000,
  parameter int PW        = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  output logic          busy,
  output logic          seq_act,
  output logic [PW-1:0] seq_idx
);
  localparam int CW = $clog2(WR_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cnt_q   <= '0;
      seq_act <= 1'b0;
      seq_idx <= '0;
    end else if (go && !busy) begin
      busy    <= 1'b1;
      cnt_q   <= '0;
      seq_act <= 1'b1;
      seq_idx <= '0;
    end else begin
      if (busy) begin
        if (cnt_q == CW'(WR_CYCLES - 1)) busy <= 1'b0;
        cnt_q <= cnt_q + 1'b1;
      end
      if (seq_act) begin
        seq_idx <= seq_idx + 1'b1;
        if (&seq_idx) seq_act <= 1'b0;
      end
    end
  end

  // R4: the window counter never passes its limit
  p_busy_bound_r4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt_q < CW'(WR_CYCLES)));
  // R4: page copy runs only inside the write window
  p_copy_in_window_r4: assert property (@(posedge clk) disable iff (rst)
    seq_act |-> busy);
endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave
  import eep_pkg::*;
#(
  parameter int PW        = 4,
  parameter int WR_CYCLES = 250000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [SEL_W-1:0] dev_sel,
  input  logic             wr_lock
);
  localparam int AW = BYTE_W;

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  eep_state_t state_q;
  logic [3:0]        bit_q;
  logic [BYTE_W-1:0] sh_q;
  logic [AW-1:0]     ptr_q;
  logic              rd_q, mack_q;

  logic busy, seq_act;
  logic [PW-1:0]     seq_idx;
  logic [BYTE_W-1:0] pb_rd_data, mem_rdata;
  logic              pb_rd_valid, pb_any;
  logic [AW-PW-1:0]  pb_page;
  logic              pb_wr, pb_clr, commit_go, mem_we, addr_hit, byte_done;

  eep_bus_sense u_sense (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  assign byte_done = scl_fall && (bit_q == 4'd8);
  assign addr_hit  = (sh_q[7:1] == {1'b0, dev_sel}) && !busy;
  assign pb_wr     = (state_q == ST_WDATA) && byte_done && !start_ev && !stop_ev;
  assign pb_clr    = start_ev && !busy;
  assign commit_go = stop_ev && (state_q == ST_WDATA || state_q == ST_WACK)
                     && pb_any && !wr_lock;
  assign mem_we    = seq_act && pb_rd_valid;

  eep_page_buf #(.AW(AW), .DW(BYTE_W), .PW(PW)) u_page (
    .clk(clk), .rst(rst), .clr(pb_clr), .wr_en(pb_wr), .wr_addr(ptr_q),
    .wr_data(sh_q), .rd_idx(seq_idx), .rd_data(pb_rd_data),
    .rd_valid(pb_rd_valid), .any_valid(pb_any), .page(pb_page)
  );

  eep_wr_cycle #(.WR_CYCLES(WR_CYCLES), .PW(PW)) u_cycle (
    .clk(clk), .rst(rst), .go(commit_go), .busy(busy),
    .seq_act(seq_act), .seq_idx(seq_idx)
  );

  eep_mem #(.AW(AW), .DW(BYTE_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr({pb_page, seq_idx}), .wdata(pb_rd_data),
    .raddr(ptr_q), .rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      rd_q    <= 1'b0;
      mack_q  <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (start_ev) begin
      state_q <= ST_ADDR;
      bit_q   <= '0;
      sda_oe  <= 1'b0;
    end else if (stop_ev) begin
      state_q <= ST_IDLE;
      sda_oe  <= 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_WADDR, ST_WDATA: begin
          if (scl_rise && bit_q != 4'd8) begin
            sh_q  <= {sh_q[6:0], sda_s};
            bit_q <= bit_q + 1'b1;
          end else if (byte_done) begin
            bit_q <= '0;
            if (state_q == ST_ADDR) begin
              if (addr_hit) begin
                sda_oe  <= 1'b1;
                rd_q    <= sh_q[0];
                state_q <= ST_AACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end else if (state_q == ST_WADDR) begin
              ptr_q   <= sh_q;
              sda_oe  <= 1'b1;
              state_q <= ST_WACK;
            end else begin
              ptr_q[PW-1:0] <= ptr_q[PW-1:0] + 1'b1;
              sda_oe  <= 1'b1;
              state_q <= ST_WACK;
            end
          end
        end
        ST_AACK: if (scl_fall) begin
          if (rd_q) begin
            sh_q    <= mem_rdata;
            sda_oe  <= ~mem_rdata[7];
            ptr_q   <= ptr_q + 1'b1;
            bit_q   <= 4'd1;
            state_q <= ST_RDATA;
          end else begin
            sda_oe  <= 1'b0;
            state_q <= ST_WADDR;
          end
        end
        ST_WACK: if (scl_fall) begin
          sda_oe  <= 1'b0;
          state_q <= ST_WDATA;
        end
        ST_RDATA: if (scl_fall) begin
          if (bit_q == 4'd8) begin
            sda_oe  <= 1'b0;
            state_q <= ST_RACK;
          end else begin
            sda_oe <= ~sh_q[6];
            sh_q   <= {sh_q[6:0], 1'b0};
            bit_q  <= bit_q + 1'b1;
          end
        end
        ST_RACK: begin
          if (scl_rise) mack_q <= ~sda_s;
          if (scl_fall) begin
            if (mack_q) begin
              sh_q    <= mem_rdata;
              sda_oe  <= ~mem_rdata[7];
              ptr_q   <= ptr_q + 1'b1;
              bit_q   <= 4'd1;
              state_q <= ST_RDATA;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R4: nothing is driven onto the bus during a write cycle
  p_quiet_busy_r4: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_oe);
  // R5: a locked stop never opens a write window
  p_lock_no_cycle_r5: assert property (@(posedge clk) disable iff (rst)
    (stop_ev && wr_lock && !busy) |=> !busy);
  // R1: a refused address leaves the line released
  p_miss_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ADDR && byte_done && !addr_hit && !start_ev && !stop_ev) |=> !sda_oe);
  // R8: each byte sent advances the pointer by one, wrapping at the top
  p_ptr_step_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RDATA && $past(state_q) != ST_RDATA) |-> (ptr_q == AW'($past(ptr_q) + 1'b1)));
  // R11: SDA only moves while SCL is low
  p_sda_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_s);
endmodule

// File: tb/eep_i2c_slave_tb.sv
module eep_i2c_slave_tb;
  localparam int WRC = 400;
  localparam int Q   = 4;
  localparam logic [5:0] SEL = 6'h2B;
  localparam logic [7:0] AW8 = {1'b0, SEL, 1'b0};
  localparam logic [7:0] AR8 = {1'b0, SEL, 1'b1};

  logic clk = 1'b0, rst = 1'b1, scl_m = 1'b1, sda_m = 1'b1, lock = 1'b0;
  logic sda_oe, sda_line;
  assign sda_line = sda_m & ~sda_oe;
  always #10 clk = ~clk;

  eep_i2c_slave #(.WR_CYCLES(WRC)) u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .dev_sel(SEL), .wr_lock(lock)
  );

  int total = 0, bad = 0;
  logic [7:0] model [256];
  logic [7:0] ptr_m = 8'h00;

  task automatic wq; repeat (Q) @(negedge clk); endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; wq; scl_m = 1'b1; wq; sda_m = 1'b0; wq; scl_m = 1'b0; wq;
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; wq; scl_m = 1'b1; wq; sda_m = 1'b1; wq;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq; scl_m = 1'b1; wq; wq; scl_m = 1'b0; wq;
    end
    sda_m = 1'b1; wq; scl_m = 1'b1; wq; ack = (sda_line == 1'b0); wq; scl_m = 1'b0; wq;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq; scl_m = 1'b1; wq; b[i] = sda_line; wq; scl_m = 1'b0;
    end
    wq; sda_m = ~give_ack; wq; scl_m = 1'b1; wq; wq; scl_m = 1'b0; wq; sda_m = 1'b1;
  endtask

  task automatic poll(output bit ack);
    i2c_start; send_byte(AW8, ack); i2c_stop;
  endtask

  task automatic page_wr(input logic [7:0] wa, input int n, input bit lk);
    bit ack;
    logic [3:0] lo;
    logic [7:0] d;
    lo = wa[3:0];
    lock = lk;
    i2c_start;
    send_byte(AW8, ack); chk(ack, "R1 write address ack", ack, 1);
    send_byte(wa, ack);  chk(ack, "R2 pointer ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      send_byte(d, ack);
      chk(ack, lk ? "R5 locked data ack" : "R2 data ack", ack, 1);
      if (!lk) model[{wa[7:4], lo}] = d;
      lo = lo + 4'd1;
    end
    ptr_m = {wa[7:4], lo};
    i2c_stop;
    poll(ack);
    if (lk) chk(ack, "R5 no write cycle after locked stop", ack, 1);
    else    chk(!ack, "R4 address refused during write cycle", ack, 0);
    lock = 1'b0;
    repeat (WRC) @(negedge clk);
    poll(ack);
    chk(ack, "R4 address accepted after write cycle", ack, 1);
  endtask

  task automatic read_run(input int n, input string tag);
    bit ack;
    logic [7:0] b;
    send_byte(AR8, ack); chk(ack, "R1 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      chk(b == model[ptr_m], tag, b, model[ptr_m]);
      ptr_m = ptr_m + 8'd1;
    end
    chk(sda_line == 1'b1, "R8 line released after nack", sda_line, 1);
    i2c_stop;
  endtask

  task automatic rand_read(input logic [7:0] wa, input int n);
    bit ack;
    i2c_start;
    send_byte(AW8, ack); chk(ack, "R7 dummy write address ack", ack, 1);
    send_byte(wa, ack);  chk(ack, "R7 pointer ack", ack, 1);
    ptr_m = wa;
    i2c_start;
    read_run(n, n > 1 ? "R8 sequential read data" : "R7 random read data");
  endtask

  task automatic cur_read(input int n);
    i2c_start;
    read_run(n, "R6 current address read data");
  endtask

  initial begin
    bit ack;
    logic [7:0] b, old;
    void'($urandom(32'd7351));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R10 SDA released after reset", sda_oe, 0);

    // fill every page
    for (int p = 0; p < 16; p++) page_wr({4'(p), 4'h0}, 16, 1'b0);
    rand_read(8'h00, 16);
    rand_read(8'hA7, 3);

    // R3: 18 bytes from 0x3C wrap inside the page; R6 pointer ends at 0x3E
    page_wr(8'h3C, 18, 1'b0);
    chk(ptr_m == 8'h3E, "R3 model pointer after wrap", ptr_m, 8'h3E);
    cur_read(1);
    rand_read(8'h30, 16);

    // R7: a write with no data starts no write cycle
    i2c_start; send_byte(AW8, ack); send_byte(8'h12, ack); i2c_stop;
    ptr_m = 8'h12;
    poll(ack); chk(ack, "R7 no write cycle after pointer only", ack, 1);
    cur_read(2);

    // R8: sequential read wraps from 255 to 0
    rand_read(8'hFE, 4);

    // R1: foreign addresses are refused
    i2c_start; send_byte({1'b1, SEL, 1'b0}, ack); i2c_stop;
    chk(!ack, "R1 leading one refused", ack, 0);
    i2c_start; send_byte({1'b0, SEL ^ 6'h01, 1'b1}, ack);
    chk(!ack, "R1 other strap refused", ack, 0);
    chk(sda_line == 1'b1, "R1 line released after miss", sda_line, 1);
    i2c_stop;

    // R5: locked write leaves memory untouched
    old = model[8'h84];
    page_wr(8'h84, 3, 1'b1);
    rand_read(8'h84, 3);
    chk(model[8'h84] == old, "R5 model untouched", model[8'h84], old);

    // R9: repeated start after data drops the buffered bytes
    old = model[8'h50];
    i2c_start; send_byte(AW8, ack); send_byte(8'h50, ack); send_byte(~old, ack);
    chk(ack, "R9 data ack before repeated start", ack, 1);
    ptr_m = 8'h51;
    i2c_start;
    read_run(1, "R9 read after discarded write");
    poll(ack); chk(ack, "R9 no write cycle after discard", ack, 1);
    rand_read(8'h50, 1);

    // random mix
    for (int k = 0; k < 14; k++) begin
      case ($urandom_range(0, 2))
        0: page_wr(8'($urandom), int'($urandom_range(1, 12)), 1'b0);
        1: rand_read(8'($urandom), int'($urandom_range(1, 5)));
        default: cur_read(int'($urandom_range(1, 3)));
      endcase
    end

    // R10: reset clears the pointer but keeps the memory
    rst = 1'b1; repeat (4) @(negedge clk); rst = 1'b0; repeat (4) @(negedge clk);
    chk(sda_oe == 1'b0, "R10 SDA released after second reset", sda_oe, 0);
    ptr_m = 8'h00;
    cur_read(2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule